// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Codec

This block guards a data word (32 bits by default) with an extended Hamming code. It has two independent combinational paths. The encode path turns a data word into a 39-bit codeword. The decode path takes a codeword, which may have been damaged while it was stored, and returns the recovered data word with a 2-bit status. There are no registers inside, so a storage array can place the encoder in front of its write port and the decoder after its read port without adding latency.

The codeword positions are numbered from 1. Check bits sit at the power-of-two positions. Data bits fill the other positions in ascending order. One last bit carries the parity of the whole word. The decoder works out a syndrome and an overall parity result. From these two values it either passes the word through unchanged, repairs one bit, or flags the word as unusable.

Top module: `secded_codec`

## Requirements
- R1: Codeword bit i (counting from 0) holds position i+1 for positions 1 to 38. Data bit j goes to the j-th position, in ascending order, whose index is not a power of two. So data bit 0 lands in codeword bit 2, and data bit 31 lands in codeword bit 37.
- R2: The check bits sit in codeword bits 0, 1, 3, 7, 15 and 31 (positions 1, 2, 4, 8, 16, 32). Check bit k makes the XOR of every position in 1..38 whose index has bit k set equal to zero.
- R3: Codeword bit 38 is the XOR of codeword bits 0 to 37, so every encoded word has even parity over all 39 bits.
- R4: A codeword without errors decodes to its data word with status 00 (clean).
- R5: A codeword with exactly one flipped bit in positions 1 to 38 decodes to the original data word with status 01 (corrected).
- R6: A codeword whose only flipped bit is bit 38 decodes to the original data word with status 01.
- R7: A codeword with any two flipped bits, bit 38 included, gives status 10 (invalid).
- R8: The status output never takes the value 11.
- R9: A nonzero syndrome above 38 together with odd overall parity gives status 10. An example is three flips at positions 1, 8 and 32.
- R10: When the status is 10, the data output holds the received data bits with no bit flipped by the decoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_data_i | input | DATA_W | Data word to encode |
| enc_code_o | output | CODE_W | Encoded word, with check bits and overall parity |
| dec_code_i | input | CODE_W | Received codeword to decode |
| dec_data_o | output | DATA_W | Recovered data word |
| dec_status_o | output | 2 | 00 clean, 01 corrected, 10 invalid |

## Verification
The bound checker holds for any fully known value on its inputs. A clean or corrected status implies a structural fact about the decoded word (it re-encodes to the input, or to a word one bit away from the input), and those facts hold whatever the input. The checks therefore take for granted only that the inputs carry no X or Z bits. The bench always drives every input bit to 0 or 1, including while its reset is held.

// File: rtl/secded_pkg.sv
package secded_pkg;

   typedef enum logic [1:0] {
      ST_CLEAN = 2'b00,
      ST_FIXED = 2'b01,
      ST_BAD   = 2'b10
   } secded_status_e;

   // number of Hamming check bits needed for a data width
   function automatic int unsigned check_bits(int unsigned dw);
      int unsigned r;
      r = 0;
      while ((1 << r) < (dw + r + 1)) r++;
      return r;
   endfunction

   function automatic bit is_pow2(int unsigned p);
      return (p != 0) && ((p & (p - 1)) == 0);
   endfunction

   // 1-based codeword position carrying data bit j
   function automatic int unsigned data_slot(int unsigned j);
      int unsigned res;
      int unsigned cnt;
      res = 0;
      cnt = 0;
      for (int unsigned p = 1; p < 4096; p++) begin
         if (res == 0 && !is_pow2(p)) begin
            if (cnt == j) res = p;
            cnt++;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/secded_parity.sv
// XOR tree: bit k of chk_o is the parity of every position whose index has bit k set
module secded_parity #(
   parameter int unsigned HAM_W = 38,
   parameter int unsigned PAR_W = 6
) (
   input  logic [HAM_W-1:0] vec_i,
   output logic [PAR_W-1:0] chk_o
);
   for (genvar k = 0; k < PAR_W; k++) begin : g_chk
      logic [HAM_W-1:0] sel;
      for (genvar p = 1; p <= HAM_W; p++) begin : g_pos
         if (((p >> k) & 1) == 1) begin : g_in
            assign sel[p-1] = vec_i[p-1];
         end else begin : g_out
            assign sel[p-1] = 1'b0;
         end
      end
      assign chk_o[k] = ^sel;
   end
endmodule

// File: rtl/secded_enc.sv
module secded_enc
   import secded_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned PAR_W  = check_bits(DATA_W),
   localparam int unsigned HAM_W  = DATA_W + PAR_W,
   localparam int unsigned CODE_W = HAM_W + 1
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CODE_W-1:0] code_o
);
   logic [HAM_W-1:0] spread;
   logic [HAM_W-1:0] ham;
   logic [PAR_W-1:0] chk;

   for (genvar j = 0; j < DATA_W; j++) begin : g_spread
      assign spread[data_slot(j)-1] = data_i[j];
   end
   for (genvar k = 0; k < PAR_W; k++) begin : g_hole
      assign spread[(1 << k)-1] = 1'b0;
   end

   secded_parity #(.HAM_W(HAM_W), .PAR_W(PAR_W)) u_par (
      .vec_i (spread),
      .chk_o (chk)
   );

   for (genvar p = 1; p <= HAM_W; p++) begin : g_ham
      if (is_pow2(p)) begin : g_chk
         assign ham[p-1] = chk[$clog2(p)];
      end else begin : g_dat
         assign ham[p-1] = spread[p-1];
      end
   end

   assign code_o = {^ham, ham};
endmodule

// File: rtl/secded_dec.sv
module secded_dec
   import secded_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned PAR_W  = check_bits(DATA_W),
   localparam int unsigned HAM_W  = DATA_W + PAR_W,
   localparam int unsigned CODE_W = HAM_W + 1
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [DATA_W-1:0] data_o,
   output secded_status_e    status_o
);
   logic [PAR_W-1:0] syn;
   logic [HAM_W-1:0] fixed;
   logic             par_odd;
   logic             syn_nz;
   logic             in_range;
   logic             do_fix;

   secded_parity #(.HAM_W(HAM_W), .PAR_W(PAR_W)) u_syn (
      .vec_i (code_i[HAM_W-1:0]),
      .chk_o (syn)
   );

   assign par_odd  = ^code_i;
   assign syn_nz   = |syn;
   assign in_range = (syn <= PAR_W'(HAM_W));
   assign do_fix   = syn_nz && par_odd && in_range;

   for (genvar p = 1; p <= HAM_W; p++) begin : g_fix
      assign fixed[p-1] = code_i[p-1] ^ (do_fix && (syn == PAR_W'(p)));
   end

   for (genvar j = 0; j < DATA_W; j++) begin : g_gather
      assign data_o[j] = fixed[data_slot(j)-1];
   end

   always_comb begin
      if (!syn_nz && !par_odd) status_o = ST_CLEAN;
      else if (!syn_nz)        status_o = ST_FIXED;
      else if (do_fix)         status_o = ST_FIXED;
      else                     status_o = ST_BAD;
   end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
   import secded_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CODE_W = DATA_W + check_bits(DATA_W) + 1
) (
   input  logic [DATA_W-1:0] enc_data_i,
   output logic [CODE_W-1:0] enc_code_o,
   input  logic [CODE_W-1:0] dec_code_i,
   output logic [DATA_W-1:0] dec_data_o,
   output logic [1:0]        dec_status_o
);
   if (DATA_W < 4 || DATA_W > 1024) begin : g_bad_width
      $error("secded_codec: DATA_W must lie in 4..1024");
   end
   if (CODE_W != DATA_W + check_bits(DATA_W) + 1) begin : g_bad_code
      $error("secded_codec: CODE_W does not match DATA_W");
   end

   secded_status_e status;

   secded_enc #(.DATA_W(DATA_W)) u_enc (
      .data_i (enc_data_i),
      .code_o (enc_code_o)
   );

   secded_dec #(.DATA_W(DATA_W)) u_dec (
      .code_i   (dec_code_i),
      .data_o   (dec_data_o),
      .status_o (status)
   );

   assign dec_status_o = status;
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CODE_W = 39
) (
   input logic [CODE_W-1:0] enc_code_o,
   input logic [CODE_W-1:0] dec_code_i,
   input logic [DATA_W-1:0] dec_data_o,
   input logic [1:0]        dec_status_o
);
   logic [CODE_W-1:0] recode;

   secded_enc #(.DATA_W(DATA_W)) u_reenc (
      .data_i (dec_data_o),
      .code_o (recode)
   );

   always_comb begin
      assert_status_legal_R8: assert (dec_status_o != 2'b11)
         else $error("status 11 produced");
      assert_enc_even_R3: assert (^enc_code_o == 1'b0)
         else $error("encoded word has odd parity");
      if (dec_status_o == 2'b00) begin
         assert_clean_exact_R4: assert (recode == dec_code_i)
            else $error("clean status but data does not re-encode to input");
      end
      if (dec_status_o == 2'b01) begin
         assert_fix_one_bit_R5: assert ($countones(recode ^ dec_code_i) == 1)
            else $error("corrected status but distance is not one bit");
      end
   end
endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
   .enc_code_o   (enc_code_o),
   .dec_code_i   (dec_code_i),
   .dec_data_o   (dec_data_o),
   .dec_status_o (dec_status_o)
);

// File: tb/test_secded_codec.sv
module test_secded_codec;

   typedef struct packed {
      logic [31:0] d;
      logic [5:0]  fa;
      logic [5:0]  fb;
      logic [1:0]  st;
   } vec_t;

   // flip positions are 1-based, 0 means none; 39 is the overall bit
   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0000, 6'd0,  6'd0,  2'b00},
      '{32'hFFFF_FFFF, 6'd0,  6'd0,  2'b00},
      '{32'h1234_5678, 6'd3,  6'd0,  2'b01},
      '{32'h8000_0000, 6'd39, 6'd0,  2'b01},
      '{32'hDEAD_BEEF, 6'd32, 6'd0,  2'b01},
      '{32'h0000_0001, 6'd16, 6'd0,  2'b01},
      '{32'hA5A5_A5A5, 6'd1,  6'd2,  2'b10},
      '{32'h0F0F_0F0F, 6'd5,  6'd39, 2'b10},
      '{32'hCAFE_F00D, 6'd38, 6'd37, 2'b10}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] enc_data;
   logic [38:0] enc_code;
   logic [38:0] dec_code;
   logic [31:0] dec_data;
   logic [1:0]  dec_status;
   int          total = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   secded_codec i_secded_codec (
      .enc_data_i   (enc_data),
      .enc_code_o   (enc_code),
      .dec_code_i   (dec_code),
      .dec_data_o   (dec_data),
      .dec_status_o (dec_status)
   );

   function automatic logic [38:0] ref_enc(logic [31:0] d);
      logic [38:0] v;
      int          j;
      v = '0;
      j = 0;
      for (int p = 1; p <= 38; p++) begin
         if ((p & (p - 1)) != 0) begin
            v[p-1] = d[j];
            j++;
         end
      end
      for (int k = 0; k < 6; k++) begin
         logic x;
         x = 1'b0;
         for (int p = 1; p <= 38; p++) if (((p >> k) & 1) == 1) x ^= v[p-1];
         v[(1 << k)-1] = x;
      end
      v[38] = ^v[37:0];
      return v;
   endfunction

   function automatic logic [31:0] ref_pick(logic [38:0] c);
      logic [31:0] d;
      int          j;
      d = '0;
      j = 0;
      for (int p = 1; p <= 38; p++) begin
         if ((p & (p - 1)) != 0) begin
            d[j] = c[p-1];
            j++;
         end
      end
      return d;
   endfunction

   function automatic logic [38:0] flip_mask(int a, int b);
      logic [38:0] m;
      m = '0;
      if (a != 0) m[a-1] = 1'b1;
      if (b != 0) m[b-1] = 1'b1;
      return m;
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_enc(logic [31:0] d);
      logic [38:0] e;
      e = ref_enc(d);
      @(posedge clk);
      enc_data = d;
      @(negedge clk);
      check(enc_code == e, "R1 R2 R3 encode", 64'(enc_code), 64'(e));
   endtask

   task automatic run_dec(logic [38:0] cw, logic [1:0] st, logic [31:0] d, string req);
      @(posedge clk);
      dec_code = cw;
      @(negedge clk);
      check(dec_status == st, {req, " status"}, 64'(dec_status), 64'(st));
      check(dec_data == d, {req, " data"}, 64'(dec_data), 64'(d));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      enc_data = '0;
      dec_code = '0;
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4: all-zero inputs after reset give a zero codeword and a clean zero word
      check(enc_code == '0, "R4 reset encode", 64'(enc_code), 64'd0);
      check(dec_status == 2'b00, "R4 reset status", 64'(dec_status), 64'd0);
      check(dec_data == '0, "R4 reset data", 64'(dec_data), 64'd0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [38:0] cw;
         logic [31:0] ed;
         run_enc(VECS[i].d);
         cw = ref_enc(VECS[i].d) ^ flip_mask(int'(VECS[i].fa), int'(VECS[i].fb));
         ed = (VECS[i].st == 2'b10) ? ref_pick(cw) : VECS[i].d;
         run_dec(cw, VECS[i].st, ed, "R4 R5 R6 R7 R10 table");
      end

      // exhaustive single and double flips over several words
      for (int w = 0; w < 6; w++) begin
         logic [31:0] d;
         logic [38:0] base;
         d = (w == 0) ? 32'hFFFF_FFFF : $urandom;
         base = ref_enc(d);
         run_enc(d);
         run_dec(base, 2'b00, d, "R4 clean");
         for (int a = 1; a <= 39; a++) begin
            run_dec(base ^ flip_mask(a, 0), 2'b01, d, (a == 39) ? "R6 overall flip" : "R5 single flip");
         end
         for (int a = 1; a <= 39; a++) begin
            for (int b = a + 1; b <= 39; b++) begin
               logic [38:0] cw;
               cw = base ^ flip_mask(a, b);
               run_dec(cw, 2'b10, ref_pick(cw), "R7 R10 double flip");
            end
         end
      end

      // R9: triple flip 1,8,32 gives syndrome 41 with odd parity
      begin
         logic [38:0] cw;
         cw = ref_enc(32'h3C3C_5AA5) ^ flip_mask(1, 8) ^ flip_mask(32, 0);
         run_dec(cw, 2'b10, ref_pick(cw), "R9 syndrome out of range");
      end

      // R8: status never 11, sampled over a spread of arbitrary words
      for (int i = 0; i < 64; i++) begin
         @(posedge clk);
         dec_code = {$urandom, $urandom};
         @(negedge clk);
         check(dec_status != 2'b11, "R8 legal status", 64'(dec_status), 64'd0);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule